// File: doc/BRIEF.md
# Cascadable Radix-4 Digit Shifter

A purely combinational parallel shifter for a word of four base-4 digits, each digit carried on two bits. A two-bit amount input moves the word by zero to three digit positions. A mode input picks one of four behaviours: a right shift, which is integer division by 4^amount; a left shift, which is integer multiplication by 4^amount; a right rotation inside the word; or a plain pass-through.

Each end of the word has a three-digit link in each direction. Digits pushed out of the word leave on a spill port. The positions that become empty are filled from a fill port. When a fill port is tied to zero, the empty positions read digit 0. To build a wider shifter, connect the spill port of one slice to the matching fill port of its neighbour; every slice gets the same mode and amount. Only the data ports and the mode and amount decode feed each output. A spill port never depends on a fill port, so a chain of slices has no combinational loop.

Top module: `digit_shifter`

## Requirements
- R1: Encodings. `mode_i` is 00 for shift right, 01 for shift left, 10 for rotate right and 11 for pass-through. Digit d of any port sits at bits [2d+1:2d], with digit 0 least significant. `amt_i` is the shift amount k, from 0 to 3. Exactly one amount is decoded at any time.
- R2: In shift right, word digit j equals input digit j+k when j+k < 4. Otherwise it equals `fill_hi_i` digit j+k-4. With `fill_hi_i` at zero the word equals `word_i` / 4^k.
- R3: In shift right, `spill_lo_o` digit m equals input digit m when m < k, and equals 0 otherwise.
- R4: In shift left, word digit j equals input digit j-k when j >= k. Otherwise it equals `fill_lo_i` digit j.
- R5: In shift left, `spill_hi_o` digit m equals input digit 4-k+m when m < k, and equals 0 otherwise. With `fill_lo_i` at zero, {`spill_hi_o`, `word_o`} equals `word_i` * 4^k.
- R6: In rotate right, word digit j equals input digit (j+k) mod 4. Both spill ports are 0, and the fill ports have no effect.
- R7: In pass-through, `word_o` equals `word_i` and both spill ports are 0, whatever the amount and fill inputs.
- R8: With k = 0, every mode gives `word_o` = `word_i` and both spill ports 0. The fill ports have no effect.
- R9: In shift right `spill_hi_o` is 0, and in shift left `spill_lo_o` is 0.
- R10: Two slices in a chain act as one 8-digit shifter. The lower slice's `spill_hi_o` drives the upper slice's `fill_lo_i`, and the upper slice's `spill_lo_o` drives the lower slice's `fill_hi_i`; the outer fill ports are tied to zero. A 16-bit value then shifted right or left by k gives value >> 2k, or (value << 2k) mod 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Operation select (R1 encoding) |
| amt_i | input | 2 | Shift amount in digits, 0 to 3 |
| word_i | input | 8 | Four-digit input word |
| fill_lo_i | input | 6 | Three digits entering at the low end on a left shift |
| fill_hi_i | input | 6 | Three digits entering at the high end on a right shift |
| word_o | output | 8 | Four-digit result word |
| spill_hi_o | output | 6 | Digits leaving the high end on a left shift |
| spill_lo_o | output | 6 | Digits leaving the low end on a right shift |

## Verification
The bench builds every instance with the default parameters: four digits of two bits each. At that size each mode can be swept over all 256 input words and all four amounts, with both zero and non-zero fill patterns, and compared against integer division, multiplication and modular rotation. A second pair of slices, wired spill-to-fill, brings the 8-digit cascade within reach. The pair is checked against 16-bit shifts of values whose digits cross the slice boundary.

// File: rtl/rshift_pkg.sv
`timescale 1ns/1ps
package rshift_pkg;

    typedef enum logic [1:0] {
        MODE_SHR  = 2'b00,
        MODE_SHL  = 2'b01,
        MODE_ROR  = 2'b10,
        MODE_PASS = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/rs_amount_decode.sv
`timescale 1ns/1ps
module rs_amount_decode #(
    parameter int AMT_W = 2,
    parameter int WAYS  = 4
) (
    input  logic [AMT_W-1:0] amt_i,
    output logic [WAYS-1:0]  hot_o
);

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            hot_o[i] = (amt_i == AMT_W'(i));
        end
    end

endmodule

// File: rtl/rs_onehot_mux.sv
`timescale 1ns/1ps
module rs_onehot_mux #(
    parameter int WIDTH = 2,
    parameter int WAYS  = 4
) (
    input  logic [WAYS-1:0]       hot_i,
    input  logic [WAYS*WIDTH-1:0] cand_i,
    output logic [WIDTH-1:0]      pick_o
);

    always_comb begin
        pick_o = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hot_i[i]) begin
                pick_o = pick_o | cand_i[i*WIDTH +: WIDTH];
            end
        end
    end

    // R1
    always_comb begin
        sel_onehot_chk: assert ($countones(hot_i) == 1)
            else $error("amount select is not one-hot: %b", hot_i);
    end

endmodule

// File: rtl/digit_shifter.sv
`timescale 1ns/1ps
module digit_shifter #(
    parameter  int DIGITS  = 4,
    parameter  int DIGIT_W = 2,
    localparam int AMT_W   = $clog2(DIGITS),
    localparam int LINKS   = DIGITS - 1,
    localparam int WORD_W  = DIGITS * DIGIT_W,
    localparam int LINK_W  = LINKS * DIGIT_W
) (
    input  logic [1:0]        mode_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [LINK_W-1:0] fill_lo_i,
    input  logic [LINK_W-1:0] fill_hi_i,
    output logic [WORD_W-1:0] word_o,
    output logic [LINK_W-1:0] spill_hi_o,
    output logic [LINK_W-1:0] spill_lo_o
);
    import rshift_pkg::*;

    localparam int CAND_W = DIGITS * DIGIT_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LINK_W-1:0] up;
        logic [LINK_W-1:0] dn;
    } result_t;

    logic [DIGIT_W-1:0] src_dig [DIGITS];
    logic [DIGIT_W-1:0] lo_dig  [LINKS];
    logic [DIGIT_W-1:0] hi_dig  [LINKS];
    logic [DIGITS-1:0]  amt_hot;
    logic [WORD_W-1:0]  shr_word;
    logic [WORD_W-1:0]  shl_word;
    logic [WORD_W-1:0]  ror_word;
    logic [LINK_W-1:0]  shl_spill;
    logic [LINK_W-1:0]  shr_spill;
    result_t            res_d;

    // split ports into digit arrays
    generate
        for (genvar d = 0; d < DIGITS; d++) begin : gen_src
            assign src_dig[d] = word_i[d*DIGIT_W +: DIGIT_W];
        end
        for (genvar m = 0; m < LINKS; m++) begin : gen_fill
            assign lo_dig[m] = fill_lo_i[m*DIGIT_W +: DIGIT_W];
            assign hi_dig[m] = fill_hi_i[m*DIGIT_W +: DIGIT_W];
        end
    endgenerate

    rs_amount_decode #(
        .AMT_W (AMT_W),
        .WAYS  (DIGITS)
    ) u_dec (
        .amt_i (amt_i),
        .hot_o (amt_hot)
    );

    // one lane per result digit and mode; candidate k is the source for amount k
    generate
        for (genvar j = 0; j < DIGITS; j++) begin : gen_word
            logic [CAND_W-1:0] c_shr;
            logic [CAND_W-1:0] c_shl;
            logic [CAND_W-1:0] c_ror;
            for (genvar k = 0; k < DIGITS; k++) begin : gen_amt
                if (j + k < DIGITS) begin : g_shr_in
                    assign c_shr[k*DIGIT_W +: DIGIT_W] = src_dig[j+k];
                end else begin : g_shr_fill
                    assign c_shr[k*DIGIT_W +: DIGIT_W] = hi_dig[j+k-DIGITS];
                end
                if (j >= k) begin : g_shl_in
                    assign c_shl[k*DIGIT_W +: DIGIT_W] = src_dig[j-k];
                end else begin : g_shl_fill
                    assign c_shl[k*DIGIT_W +: DIGIT_W] = lo_dig[j];
                end
                assign c_ror[k*DIGIT_W +: DIGIT_W] = src_dig[(j+k) % DIGITS];
            end
            rs_onehot_mux #(.WIDTH(DIGIT_W), .WAYS(DIGITS)) u_shr (
                .hot_i  (amt_hot),
                .cand_i (c_shr),
                .pick_o (shr_word[j*DIGIT_W +: DIGIT_W])
            );
            rs_onehot_mux #(.WIDTH(DIGIT_W), .WAYS(DIGITS)) u_shl (
                .hot_i  (amt_hot),
                .cand_i (c_shl),
                .pick_o (shl_word[j*DIGIT_W +: DIGIT_W])
            );
            rs_onehot_mux #(.WIDTH(DIGIT_W), .WAYS(DIGITS)) u_ror (
                .hot_i  (amt_hot),
                .cand_i (c_ror),
                .pick_o (ror_word[j*DIGIT_W +: DIGIT_W])
            );
        end

        for (genvar m = 0; m < LINKS; m++) begin : gen_link
            logic [CAND_W-1:0] c_up;
            logic [CAND_W-1:0] c_dn;
            for (genvar k = 0; k < DIGITS; k++) begin : gen_amt
                if (m < k) begin : g_out
                    assign c_up[k*DIGIT_W +: DIGIT_W] = src_dig[DIGITS-k+m];
                    assign c_dn[k*DIGIT_W +: DIGIT_W] = src_dig[m];
                end else begin : g_idle
                    assign c_up[k*DIGIT_W +: DIGIT_W] = '0;
                    assign c_dn[k*DIGIT_W +: DIGIT_W] = '0;
                end
            end
            rs_onehot_mux #(.WIDTH(DIGIT_W), .WAYS(DIGITS)) u_up (
                .hot_i  (amt_hot),
                .cand_i (c_up),
                .pick_o (shl_spill[m*DIGIT_W +: DIGIT_W])
            );
            rs_onehot_mux #(.WIDTH(DIGIT_W), .WAYS(DIGITS)) u_dn (
                .hot_i  (amt_hot),
                .cand_i (c_dn),
                .pick_o (shr_spill[m*DIGIT_W +: DIGIT_W])
            );
        end
    endgenerate

    // mode select
    always_comb begin
        res_d = '0;
        case (shift_mode_e'(mode_i))
            MODE_SHR: begin
                res_d.word = shr_word;
                res_d.dn   = shr_spill;
            end
            MODE_SHL: begin
                res_d.word = shl_word;
                res_d.up   = shl_spill;
            end
            MODE_ROR: begin
                res_d.word = ror_word;
            end
            default: begin
                res_d.word = word_i;
            end
        endcase
    end

    assign word_o     = res_d.word;
    assign spill_hi_o = res_d.up;
    assign spill_lo_o = res_d.dn;

    // numeric cross-checks of the lane network
    logic [WORD_W-1:0]   keep_mask;
    logic [LINK_W-1:0]   lost_mask;
    logic [2*WORD_W-1:0] unrot;

    always_comb begin
        keep_mask = {WORD_W{1'b1}} >> (DIGIT_W * amt_i);
        lost_mask = ~({LINK_W{1'b1}} << (DIGIT_W * amt_i));
        unrot     = {word_o, word_o} << (DIGIT_W * amt_i);
        if (mode_i == MODE_SHR) begin
            // R2
            shr_quotient_chk: assert ((word_o & keep_mask) == (word_i >> (DIGIT_W * amt_i)))
                else $error("right shift quotient mismatch");
            // R3
            shr_spill_chk: assert (spill_lo_o == (LINK_W'(word_i) & lost_mask))
                else $error("right shift spill mismatch");
            // R9
            shr_quiet_chk: assert (spill_hi_o == '0)
                else $error("high spill active in right shift");
        end
        if (mode_i == MODE_SHL) begin
            // R5
            shl_product_chk: assert (({spill_hi_o, word_o} >> (DIGIT_W * amt_i)) == {{LINK_W{1'b0}}, word_i})
                else $error("left shift product mismatch");
            // R9
            shl_quiet_chk: assert (spill_lo_o == '0)
                else $error("low spill active in left shift");
        end
        if (mode_i == MODE_ROR) begin
            // R6
            ror_inverse_chk: assert (unrot[2*WORD_W-1:WORD_W] == word_i && spill_hi_o == '0 && spill_lo_o == '0)
                else $error("rotation not invertible");
        end
        if (mode_i == MODE_PASS) begin
            // R7
            pass_through_chk: assert (word_o == word_i && spill_hi_o == '0 && spill_lo_o == '0)
                else $error("pass-through altered data");
        end
        if (amt_i == '0) begin
            // R8
            zero_amount_chk: assert (word_o == word_i && spill_hi_o == '0 && spill_lo_o == '0)
                else $error("zero amount altered data");
        end
    end

endmodule

// File: tb/tb_digit_shifter.sv
`timescale 1ns/1ps
module tb_digit_shifter;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [1:0] mode;
    logic [1:0] amt;
    logic [7:0] word;
    logic [5:0] fill_lo;
    logic [5:0] fill_hi;
    logic [7:0] word_q;
    logic [5:0] spill_hi;
    logic [5:0] spill_lo;

    digit_shifter dut (
        .mode_i     (mode),
        .amt_i      (amt),
        .word_i     (word),
        .fill_lo_i  (fill_lo),
        .fill_hi_i  (fill_hi),
        .word_o     (word_q),
        .spill_hi_o (spill_hi),
        .spill_lo_o (spill_lo)
    );

    // two-slice chain for R10
    logic [15:0] cval;
    logic [7:0]  c_lo_w;
    logic [7:0]  c_hi_w;
    logic [5:0]  lo_up;
    logic [5:0]  lo_dn;
    logic [5:0]  hi_up;
    logic [5:0]  hi_dn;

    digit_shifter u_chain_lo (
        .mode_i     (mode),
        .amt_i      (amt),
        .word_i     (cval[7:0]),
        .fill_lo_i  (6'd0),
        .fill_hi_i  (hi_dn),
        .word_o     (c_lo_w),
        .spill_hi_o (lo_up),
        .spill_lo_o (lo_dn)
    );

    digit_shifter u_chain_hi (
        .mode_i     (mode),
        .amt_i      (amt),
        .word_i     (cval[15:8]),
        .fill_lo_i  (lo_up),
        .fill_hi_i  (6'd0),
        .word_o     (c_hi_w),
        .spill_hi_o (hi_up),
        .spill_lo_o (hi_dn)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (mode %0d amt %0d word %0h)",
                     req, act, exp, mode, amt, word);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [1:0] k, input logic [7:0] w,
                         input logic [5:0] fl, input logic [5:0] fh);
        @(negedge clk);
        mode    = m;
        amt     = k;
        word    = w;
        fill_lo = fl;
        fill_hi = fh;
        #1;
    endtask

    task automatic t_idle();
        drive(2'b00, 2'd0, 8'h00, 6'h00, 6'h00);
        chk("R1 idle word", int'(word_q), 0);
        chk("R1 idle spill_hi", int'(spill_hi), 0);
        chk("R1 idle spill_lo", int'(spill_lo), 0);
    endtask

    task automatic t_right();
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 256; w++) begin
                for (int f = 0; f < 2; f++) begin
                    int fh;
                    int ew;
                    fh = (f == 0) ? 0 : 'h2D;
                    drive(2'b00, 2'(k), 8'(w), 6'h3F, 6'(fh));
                    ew = (((fh << 8) | w) >> (2 * k)) & 'hFF;
                    chk(k == 0 ? "R8 right word" : "R2 right word", int'(word_q), ew);
                    chk("R3 right spill_lo", int'(spill_lo), w & ((1 << (2 * k)) - 1));
                    chk("R9 right spill_hi", int'(spill_hi), 0);
                end
            end
        end
    endtask

    task automatic t_left();
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 256; w++) begin
                for (int f = 0; f < 2; f++) begin
                    int fl;
                    int ew;
                    fl = (f == 0) ? 0 : 'h36;
                    drive(2'b01, 2'(k), 8'(w), 6'(fl), 6'h3F);
                    ew = ((w << (2 * k)) | (fl & ((1 << (2 * k)) - 1))) & 'hFF;
                    chk(k == 0 ? "R8 left word" : "R4 left word", int'(word_q), ew);
                    chk("R5 left spill_hi", int'(spill_hi), (w << (2 * k)) >> 8);
                    chk("R9 left spill_lo", int'(spill_lo), 0);
                end
            end
        end
    endtask

    task automatic t_rotate();
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 256; w++) begin
                drive(2'b10, 2'(k), 8'(w), 6'(w % 64), 6'(63 - (w % 64)));
                chk("R6 rotate word", int'(word_q), ((w | (w << 8)) >> (2 * k)) & 'hFF);
                chk("R6 rotate spills", int'({spill_hi, spill_lo}), 0);
            end
        end
    endtask

    task automatic t_pass();
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < 256; w += 17) begin
                drive(2'b11, 2'(k), 8'(w), 6'h2A, 6'h15);
                chk("R7 pass word", int'(word_q), w);
                chk("R7 pass spills", int'({spill_hi, spill_lo}), 0);
            end
        end
    endtask

    task automatic t_chain();
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 64; p++) begin
                logic [15:0] v;
                v = 16'(p * 1031 + 16'hC35A * (p & 3) + 16'h9E37 * k);
                @(negedge clk);
                cval = v;
                mode = 2'b00;
                amt  = 2'(k);
                #1;
                chk("R10 chain right", int'({c_hi_w, c_lo_w}), int'(v >> (2 * k)));
                @(negedge clk);
                mode = 2'b01;
                #1;
                chk("R10 chain left", int'({c_hi_w, c_lo_w}), int'(16'(v << (2 * k))));
            end
        end
    endtask

    initial begin
        mode    = 2'b00;
        amt     = 2'd0;
        word    = 8'h00;
        fill_lo = 6'h00;
        fill_hi = 6'h00;
        cval    = 16'h0000;
        t_idle();
        t_right();
        t_left();
        t_rotate();
        t_pass();
        t_chain();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(190000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule